// File: doc/BRIEF.md
# Three-Level Interrupt In-Service Tracker

This block sits beside a small microcontroller core and records which interrupt priority levels are being serviced. There are three levels. From highest to lowest they are power-fail, high and low. Pending requests come in per level: one power-fail line, and `N_SRC` lines each for high and low. From these requests and the current in-service state, the block decides whether a new request may preempt. It also reports the winning level and that request's vector address. An acknowledge from the CPU marks the granted level as in service. A return-from-interrupt pulse retires the innermost active level.

The same status byte also shows two serial-port activity flags, so software can poll them. The block also guards the clock-divisor field. A write to that field is dropped while either serial flag is set, which keeps an active transfer from being disturbed by a clock-rate change.

Top module: `isr_level_tracker`

## Requirements
- R1: The three levels are ordered power-fail above high above low. When the power-fail request is active and power-fail is not in service, the grant is 1 and the granted level is power-fail. The level code is 2 for power-fail, 1 for high and 0 for low.
- R2: `status_o` bit 7 reads 1 while power-fail is in service, bit 6 while high is in service and bit 5 while low is in service. Bits 4 to 2 read 0.
- R3: A request is not granted while its own level or any higher level is in service. `grant_o` is 1 only if some level with an active request has neither itself nor a higher level in service.
- R4: At a clock edge where `ack_i` and `grant_o` are both 1, the in-service bit of the granted level is set. An acknowledge while `grant_o` is 0 changes nothing.
- R5: A clock edge with `reti_i` high clears the highest set in-service bit. When no level is in service, it has no effect.
- R6: When `reti_i` and an effective acknowledge occur in the same cycle, the highest set bit is cleared first. Then the bit of the level granted in that cycle is set.
- R7: Within the winning level, the lowest-numbered active source wins. `vec_o` is 0x0033 for power-fail, 0x0003 + 8·index for high and 0x0043 + 8·index for low. It is 0 when nothing is granted, and it holds the winner's value in the acknowledge cycle.
- R8: A write strobe on `div_wr_i` loads `div_wdata_i` into `div_o` at the next edge. The write is ignored, and `div_o` keeps its value, while `tx_busy_i` or `rx_busy_i` is 1.
- R9: `status_o` bit 1 follows `rx_busy_i` and bit 0 follows `tx_busy_i`, without delay.
- R10: While `rst_n` is low, no level is in service and `div_o` equals `DIV_RST`, which is 0 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pf_i | input | 1 | Power-fail request |
| irq_hi_i | input | N_SRC | High-level requests, index 0 preferred |
| irq_lo_i | input | N_SRC | Low-level requests, index 0 preferred |
| ack_i | input | 1 | CPU acknowledge of the current grant |
| reti_i | input | 1 | Return-from-interrupt pulse |
| tx_busy_i | input | 1 | Serial transmit activity |
| rx_busy_i | input | 1 | Serial receive activity |
| div_wr_i | input | 1 | Clock-divisor write strobe |
| div_wdata_i | input | DIV_W | Clock-divisor write data |
| grant_o | output | 1 | A pending request may preempt now |
| grant_lvl_o | output | 2 | Granted level: 2 power-fail, 1 high, 0 low |
| vec_o | output | VEC_W | Vector address of the winning source |
| status_o | output | 8 | In-service bits 7..5, rx activity bit 1, tx activity bit 0 |
| div_o | output | DIV_W | Current clock-divisor value |

## Verification
Two functions can fall in the same cycle: the acknowledge that opens a new service level and the return that closes the innermost one. Both change the in-service bits at the same edge. The bench provokes this directly: with low in service it raises a high request and pulses acknowledge and return together, then expects only the high bit to remain. Random traffic then sets both strobes independently over thousands of cycles. A reference model applies the clear-then-set order and is compared with the status bits every cycle.

// File: rtl/isr_level_tracker.sv
module isr_level_tracker #(
  parameter int N_SRC   = 4,
  parameter int DIV_W   = 2,
  parameter int VEC_W   = 16,
  parameter int PF_VEC  = 'h33,
  parameter int HI_BASE = 'h03,
  parameter int LO_BASE = 'h43,
  parameter int STRIDE  = 8,
  parameter int DIV_RST = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pf_i,
  input  logic [N_SRC-1:0] irq_hi_i,
  input  logic [N_SRC-1:0] irq_lo_i,
  input  logic             ack_i,
  input  logic             reti_i,
  input  logic             tx_busy_i,
  input  logic             rx_busy_i,
  input  logic             div_wr_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  output logic             grant_o,
  output logic [1:0]       grant_lvl_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [7:0]       status_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  function automatic logic [IDX_W-1:0] first_set(input logic [N_SRC-1:0] v);
    first_set = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (v[i]) first_set = IDX_W'(i);
  endfunction

  logic [2:0] isv, isv_nx;
  logic       pf_ok, hi_ok, lo_ok;

  assign pf_ok = irq_pf_i && !isv[2];
  assign hi_ok = (|irq_hi_i) && (isv[2:1] == 2'b00);
  assign lo_ok = (|irq_lo_i) && (isv == 3'b000);

  assign grant_o     = pf_ok | hi_ok | lo_ok;
  assign grant_lvl_o = pf_ok ? 2'd2 : (hi_ok ? 2'd1 : 2'd0);

  always_comb begin
    if (pf_ok)
      vec_o = VEC_W'(PF_VEC);
    else if (hi_ok)
      vec_o = VEC_W'(HI_BASE) + VEC_W'(STRIDE) * VEC_W'(first_set(irq_hi_i));
    else if (lo_ok)
      vec_o = VEC_W'(LO_BASE) + VEC_W'(STRIDE) * VEC_W'(first_set(irq_lo_i));
    else
      vec_o = '0;
  end

  always_comb begin
    isv_nx = isv;
    if (reti_i) begin
      if (isv[2])      isv_nx[2] = 1'b0;
      else if (isv[1]) isv_nx[1] = 1'b0;
      else             isv_nx[0] = 1'b0;
    end
    if (ack_i && grant_o) isv_nx[grant_lvl_o] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isv   <= '0;
      div_o <= DIV_W'(DIV_RST);
    end else begin
      isv <= isv_nx;
      if (div_wr_i && !(tx_busy_i || rx_busy_i)) div_o <= div_wdata_i;
    end
  end

  assign status_o = {isv, 3'b000, rx_busy_i, tx_busy_i};
endmodule

// File: rtl/isr_level_tracker_chk.sv
module isr_level_tracker_chk #(
  parameter int DIV_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_pf_i,
  input logic             ack_i,
  input logic             reti_i,
  input logic             tx_busy_i,
  input logic             rx_busy_i,
  input logic             div_wr_i,
  input logic             grant_o,
  input logic [1:0]       grant_lvl_o,
  input logic [2:0]       isv_bits,
  input logic [DIV_W-1:0] div_o
);
  AST_PF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pf_i && !isv_bits[2]) |-> (grant_o && grant_lvl_o == 2'd2)); // R1

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (isv_bits[2] || (isv_bits[1] && !irq_pf_i)) |-> !grant_o); // R3

  AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && grant_o) |=> |(isv_bits & (3'b001 << $past(grant_lvl_o)))); // R4

  AST_RETI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !ack_i && isv_bits == 3'b000) |=> isv_bits == 3'b000); // R5

  AST_DIV_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (div_wr_i && (tx_busy_i || rx_busy_i)) |=> $stable(div_o)); // R8
endmodule

bind isr_level_tracker isr_level_tracker_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_pf_i(irq_pf_i), .ack_i(ack_i), .reti_i(reti_i),
  .tx_busy_i(tx_busy_i), .rx_busy_i(rx_busy_i), .div_wr_i(div_wr_i),
  .grant_o(grant_o), .grant_lvl_o(grant_lvl_o), .isv_bits(status_o[7:5]), .div_o(div_o)
);

// File: tb/isr_level_tracker_tb_top.sv
`timescale 1ns/1ps
module isr_level_tracker_tb_top;
  localparam int N = 4;
  localparam int DW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_pf = 1'b0, ack = 1'b0, reti = 1'b0, tx = 1'b0, rx = 1'b0, wr = 1'b0;
  logic [N-1:0] irq_hi = '0, irq_lo = '0;
  logic [DW-1:0] wdata = '0;
  logic grant;
  logic [1:0] lvl;
  logic [15:0] vec;
  logic [7:0] status;
  logic [DW-1:0] div;

  int checks = 0, fails = 0;
  logic [2:0] m_isv = '0;
  logic [DW-1:0] m_div = '0;

  always #2 clk = ~clk;

  isr_level_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pf_i(irq_pf), .irq_hi_i(irq_hi), .irq_lo_i(irq_lo),
    .ack_i(ack), .reti_i(reti), .tx_busy_i(tx), .rx_busy_i(rx), .div_wr_i(wr),
    .div_wdata_i(wdata), .grant_o(grant), .grant_lvl_o(lvl), .vec_o(vec),
    .status_o(status), .div_o(div)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int low_idx(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [2:0] ok_mask(input logic [2:0] s);
    ok_mask[2] = irq_pf && !s[2];
    ok_mask[1] = (|irq_hi) && !s[2] && !s[1];
    ok_mask[0] = (|irq_lo) && (s == 3'b000);
  endfunction

  function automatic logic [1:0] exp_lvl(input logic [2:0] ok);
    return ok[2] ? 2'd2 : (ok[1] ? 2'd1 : 2'd0);
  endfunction

  function automatic logic [15:0] exp_vec(input logic [2:0] ok);
    if (ok[2]) return 16'h0033;
    if (ok[1]) return 16'(16'h0003 + 8 * low_idx(irq_hi));
    if (ok[0]) return 16'(16'h0043 + 8 * low_idx(irq_lo));
    return 16'h0000;
  endfunction

  task automatic step(input logic pf, input logic [N-1:0] hi, input logic [N-1:0] lo,
                      input logic a, input logic r, input logic t, input logic x,
                      input logic w, input logic [DW-1:0] d);
    logic [2:0] ok;
    logic [2:0] nx;
    @(negedge clk);
    irq_pf = pf; irq_hi = hi; irq_lo = lo; ack = a; reti = r;
    tx = t; rx = x; wr = w; wdata = d;
    #1;
    ok = ok_mask(m_isv);
    chk("R3 grant", grant, |ok);
    if (|ok) chk("R1 level", lvl, exp_lvl(ok));
    chk("R7 vector", vec, exp_vec(ok));
    chk("R2 in-service bits", status[7:2], {m_isv, 3'b000});
    chk("R9 activity bits", status[1:0], {x, t});
    chk("R8 divisor", div, m_div);
    @(posedge clk);
    nx = m_isv;
    if (r) begin
      if (nx[2]) nx[2] = 1'b0;
      else if (nx[1]) nx[1] = 1'b0;
      else nx[0] = 1'b0;
    end
    if (a && (|ok)) nx[exp_lvl(ok)] = 1'b1;
    m_isv = nx;
    if (w && !(t || x)) m_div = d;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset in-service", status[7:5], 3'b000);
    chk("R10 reset divisor", div, '0);
    @(negedge clk); rst_n = 1'b1;

    // nested preemption: low, high, power-fail (R4)
    step(1'b0, 4'b0000, 4'b0100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    #1 chk("R4 low set", status[7:5], 3'b001);
    step(1'b0, 4'b0000, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    #1 chk("R3 same-level blocked", status[7:5], 3'b001);
    step(1'b0, 4'b1010, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    #1 chk("R4 high nests", status[7:5], 3'b011);
    step(1'b1, 4'b0001, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    #1 chk("R4 power-fail nests", status[7:5], 3'b111);
    step(1'b1, 4'b1111, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    // unwind (R5)
    step(1'b0, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    #1 chk("R5 clears power-fail", status[7:5], 3'b011);
    step(1'b0, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    step(1'b0, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    #1 chk("R5 all cleared", status[7:5], 3'b000);
    step(1'b0, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    #1 chk("R5 return when idle", status[7:5], 3'b000);
    // coincident acknowledge and return (R6)
    step(1'b0, 4'b0000, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    step(1'b0, 4'b0100, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    #1 chk("R6 clear then set", status[7:5], 3'b010);
    step(1'b0, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    // divisor lockout (R8)
    step(1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3);
    #1 chk("R8 locked by tx", div, 2'd0);
    step(1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2);
    #1 chk("R8 locked by rx", div, 2'd0);
    step(1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2);
    #1 chk("R8 write taken", div, 2'd2);

    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 8) == 0, N'($urandom) & N'($urandom), N'($urandom) & N'($urandom),
           ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0,
           ($urandom % 3) == 0, ($urandom % 2) == 0, DW'($urandom));
    end
    step(1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule